// File: doc/BRIEF.md
# Hierarchical Reset Domain Controller

This block turns a handful of reset sources into one active-low reset line per domain of a processor subsystem. The sources are two power-good levels (processor supply and fabric supply), externally requested cold and warm reset levels, a set of watchdog timeout pulses, a debugger reset request and software writes to a small register port. Domains nest: power-on covers cold, and cold covers warm. Each domain output is decoded from these sources and registered, so every output changes one clock edge after the input that caused it.

Three domain kinds behave differently from a plain level follower. The system-configuration domain is held for as long as power-on is active, but a cold or warm request only gives it a short fixed pulse. The three peripheral domains and the bridge domain are set into reset by hardware, and only software can release them by clearing a hold bit. The bridge and memory-port domains can be shielded from warm-class events by mask bits. Warm-class events are external warm requests, watchdog timeouts and software-triggered warm reset.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While rst_ni is low every domain output is driven low (asserted).
- R2: The power-on output and the debug-port (TAP) output are low while either power-good input is low, and go high one clock after both are high. No other source asserts the TAP output.
- R3: A cold request asserts the cold, warm, debug, per-core cold and per-core warm outputs; a warm request asserts warm and per-core warm but leaves cold, debug and per-core cold high. Outputs follow the request level one clock later.
- R4: The system-configuration output is low whenever the power-on output is low.
- R5: A rising edge on the cold or warm request drives the system-configuration output low for exactly PULSE_LEN (default 4) clocks starting one clock after the edge, then releases it even if the request stays high.
- R6: The debug output asserts on power-on, cold request, the debugger request input or the software debug bit, and never on warm-class events.
- R7: Register address 1 holds software requests: bits [3:0] assert the per-core cold reset of core 0..3 (which also asserts that core's warm reset), bits [7:4] assert only the per-core warm reset of core 0..3, bit 8 asserts debug, and bit 9 is a self-clearing trigger for one warm-class event. Software request bits take effect two clocks after the write edge.
- R8: Hold register at address 0 (bit 0 fast peripheral, bit 1 peripheral, bit 2 slow peripheral, bit 3 bridge): any power-on, cold or warm-class event sets the peripheral hold bits, and the matching output stays low until software writes 0 to the bit; when an event and a write fall in the same cycle the event wins.
- R9: The bridge hold bit is set by power-on, cold and unmasked warm-class events, and software may also set it by writing 1; mask register address 2 bit 0 shields it from warm-class events.
- R10: The memory-port output follows power-on, cold and warm-class events as a level and releases by itself; mask register bit 1 shields it from warm-class events.
- R11: A one-cycle pulse on any watchdog timeout line asserts the warm domain for one clock and sets the peripheral hold bits.
- R12: The software warm trigger (address 1 bit 9) acts as a warm-class event: it asserts warm and per-core warm for one clock, sets holds, and obeys the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| proc_pgood_i | input | 1 | Processor supply power-good |
| fab_pgood_i | input | 1 | Fabric supply power-good |
| cold_req_i | input | 1 | External cold reset request level |
| warm_req_i | input | 1 | External warm reset request level |
| wdog_to_i | input | N_WDOG | Watchdog timeout pulses |
| dbg_req_i | input | 1 | Debugger reset request level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 hold, 1 requests, 2 masks) |
| reg_wdata_i | input | 2*N_CORE+2 | Register write data |
| por_rst_no | output | 1 | Power-on domain reset |
| cold_rst_no | output | 1 | Cold domain reset |
| warm_rst_no | output | 1 | Warm domain reset |
| syscfg_rst_no | output | 1 | System-configuration domain reset |
| dbg_rst_no | output | 1 | Debug domain reset |
| core_cold_rst_no | output | N_CORE | Per-core cold reset |
| core_warm_rst_no | output | N_CORE | Per-core warm reset |
| fper_rst_no | output | 1 | Fast peripheral domain reset |
| per_rst_no | output | 1 | Peripheral domain reset |
| sper_rst_no | output | 1 | Slow peripheral domain reset |
| bridge_rst_no | output | 1 | Bridge domain reset |
| memport_rst_no | output | 1 | Memory-port domain reset |
| tap_rst_no | output | 1 | Debug-port (TAP) domain reset |

## Verification
The contested cycle is a hardware event setting a hold bit in the same clock as a software write clearing it. The bench raises a watchdog pulse in the very cycle it writes zero to the hold register, and expects the fast peripheral output to stay low with the warm output low for that clock; a later write with no event must then release it. The system-configuration pulse is also judged while the warm or cold request is still held, so its end is checked against the level that continues to assert the other domains.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_HOLD = 2'd0;
  localparam logic [ADDR_W-1:0] A_REQ  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

  localparam int unsigned NUM_HOLD = 4;
  localparam int unsigned H_FPER   = 0;
  localparam int unsigned H_PER    = 1;
  localparam int unsigned H_SPER   = 2;
  localparam int unsigned H_BRIDGE = 3;

  localparam int unsigned NUM_MASK = 2;
  localparam int unsigned M_BRIDGE = 0;
  localparam int unsigned M_MEM    = 1;
endpackage

// File: rtl/rdc_sw_regs.sv
module rdc_sw_regs
  import rdc_pkg::*;
#(
  parameter int unsigned N_CORE = 4,
  localparam int unsigned REG_W = 2 * N_CORE + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [N_CORE-1:0]   core_cold_sw_o,
  output logic [N_CORE-1:0]   core_warm_sw_o,
  output logic                dbg_sw_o,
  output logic                warm_sw_o,
  output logic [NUM_MASK-1:0] mask_o
);
  localparam int unsigned DBG_BIT  = 2 * N_CORE;
  localparam int unsigned WARM_BIT = 2 * N_CORE + 1;

  logic req_wr, mask_wr;
  assign req_wr  = reg_we_i && (reg_addr_i == A_REQ);
  assign mask_wr = reg_we_i && (reg_addr_i == A_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_cold_sw_o <= '0;
      core_warm_sw_o <= '0;
      dbg_sw_o       <= 1'b0;
      warm_sw_o      <= 1'b0;
      mask_o         <= '0;
    end else begin
      warm_sw_o <= req_wr & reg_wdata_i[WARM_BIT];  // one-shot trigger
      if (req_wr) begin
        core_cold_sw_o <= reg_wdata_i[N_CORE-1:0];
        core_warm_sw_o <= reg_wdata_i[2*N_CORE-1:N_CORE];
        dbg_sw_o       <= reg_wdata_i[DBG_BIT];
      end
      if (mask_wr) mask_o <= reg_wdata_i[NUM_MASK-1:0];
    end
  end
endmodule

// File: rtl/rdc_cfg_pulse.sv
module rdc_cfg_pulse #(
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic cold_req_i,
  input  logic warm_req_i,
  output logic syscfg_assert_o
);
  logic             cold_prev_q, warm_prev_q, rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign rise = (cold_req_i & ~cold_prev_q) | (warm_req_i & ~warm_prev_q);

  always_comb begin
    if (rise)              cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_prev_q     <= 1'b0;
      warm_prev_q     <= 1'b0;
      cnt_q           <= '0;
      syscfg_assert_o <= 1'b1;
    end else begin
      cold_prev_q     <= cold_req_i;
      warm_prev_q     <= warm_req_i;
      cnt_q           <= cnt_d;
      syscfg_assert_o <= por_i | (cnt_d != '0);  // level on power-on, pulse otherwise
    end
  end
endmodule

// File: rtl/rdc_hold_bank.sv
module rdc_hold_bank #(
  parameter int unsigned NH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NH-1:0] set_i,
  input  logic          we_i,
  input  logic [NH-1:0] wdata_i,
  output logic [NH-1:0] hold_o
);
  for (genvar i = 0; i < NH; i++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hold_o[i] <= 1'b1;
      else if (set_i[i]) hold_o[i] <= 1'b1;  // hardware event beats software clear
      else if (we_i)     hold_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
  import rdc_pkg::*;
#(
  parameter int unsigned N_CORE    = 4,
  parameter int unsigned N_WDOG    = 4,
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned REG_W    = 2 * N_CORE + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_pgood_i,
  input  logic              fab_pgood_i,
  input  logic              cold_req_i,
  input  logic              warm_req_i,
  input  logic [N_WDOG-1:0] wdog_to_i,
  input  logic              dbg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              por_rst_no,
  output logic              cold_rst_no,
  output logic              warm_rst_no,
  output logic              syscfg_rst_no,
  output logic              dbg_rst_no,
  output logic [N_CORE-1:0] core_cold_rst_no,
  output logic [N_CORE-1:0] core_warm_rst_no,
  output logic              fper_rst_no,
  output logic              per_rst_no,
  output logic              sper_rst_no,
  output logic              bridge_rst_no,
  output logic              memport_rst_no,
  output logic              tap_rst_no
);
  logic [N_CORE-1:0]   core_cold_sw, core_warm_sw;
  logic                dbg_sw, warm_sw;
  logic [NUM_MASK-1:0] mask;

  rdc_sw_regs #(.N_CORE(N_CORE)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .core_cold_sw_o(core_cold_sw), .core_warm_sw_o(core_warm_sw),
    .dbg_sw_o(dbg_sw), .warm_sw_o(warm_sw), .mask_o(mask)
  );

  // event decode, nested power-on > cold > warm
  logic por_c, cold_c, warm_evt_c, warm_c, dbg_c, mem_c;
  logic [N_CORE-1:0] core_cold_c, core_warm_c;

  assign por_c       = ~(proc_pgood_i & fab_pgood_i);
  assign cold_c      = por_c | cold_req_i;
  assign warm_evt_c  = warm_req_i | warm_sw | (|wdog_to_i);
  assign warm_c      = cold_c | warm_evt_c;
  assign dbg_c       = cold_c | dbg_sw | dbg_req_i;
  assign core_cold_c = {N_CORE{cold_c}} | core_cold_sw;
  assign core_warm_c = {N_CORE{warm_c}} | core_warm_sw | core_cold_sw;
  assign mem_c       = cold_c | (warm_evt_c & ~mask[M_MEM]);

  logic [NUM_HOLD-1:0] hold_set, hold_q;
  always_comb begin
    hold_set           = '0;
    hold_set[H_FPER]   = warm_c;
    hold_set[H_PER]    = warm_c;
    hold_set[H_SPER]   = warm_c;
    hold_set[H_BRIDGE] = cold_c | (warm_evt_c & ~mask[M_BRIDGE]);
  end

  rdc_hold_bank #(.NH(NUM_HOLD)) u_hold (
    .clk_i, .rst_ni,
    .set_i   (hold_set),
    .we_i    (reg_we_i && (reg_addr_i == A_HOLD)),
    .wdata_i (reg_wdata_i[NUM_HOLD-1:0]),
    .hold_o  (hold_q)
  );

  logic syscfg_q;
  rdc_cfg_pulse #(.PULSE_LEN(PULSE_LEN)) u_cfg (
    .clk_i, .rst_ni, .por_i(por_c), .cold_req_i, .warm_req_i,
    .syscfg_assert_o(syscfg_q)
  );

  logic por_q, cold_q, warm_q, dbg_q, mem_q;
  logic [N_CORE-1:0] core_cold_q, core_warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q       <= 1'b1;
      cold_q      <= 1'b1;
      warm_q      <= 1'b1;
      dbg_q       <= 1'b1;
      mem_q       <= 1'b1;
      core_cold_q <= '1;
      core_warm_q <= '1;
    end else begin
      por_q       <= por_c;
      cold_q      <= cold_c;
      warm_q      <= warm_c;
      dbg_q       <= dbg_c;
      mem_q       <= mem_c;
      core_cold_q <= core_cold_c;
      core_warm_q <= core_warm_c;
    end
  end

  assign por_rst_no       = ~por_q;
  assign tap_rst_no       = ~por_q;
  assign cold_rst_no      = ~cold_q;
  assign warm_rst_no      = ~warm_q;
  assign syscfg_rst_no    = ~syscfg_q;
  assign dbg_rst_no       = ~dbg_q;
  assign memport_rst_no   = ~mem_q;
  assign core_cold_rst_no = ~core_cold_q;
  assign core_warm_rst_no = ~core_warm_q;
  assign fper_rst_no      = ~hold_q[H_FPER];
  assign per_rst_no       = ~hold_q[H_PER];
  assign sper_rst_no      = ~hold_q[H_SPER];
  assign bridge_rst_no    = ~hold_q[H_BRIDGE];
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker
  import rdc_pkg::*;
#(
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_WDOG = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              warm_req_i,
  input logic [N_WDOG-1:0] wdog_to_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              por_rst_no,
  input logic              cold_rst_no,
  input logic              warm_rst_no,
  input logic              syscfg_rst_no,
  input logic              dbg_rst_no,
  input logic [N_CORE-1:0] core_cold_rst_no,
  input logic [N_CORE-1:0] core_warm_rst_no,
  input logic              fper_rst_no,
  input logic              per_rst_no,
  input logic              sper_rst_no,
  input logic              memport_rst_no
);
  a_r3_cold_in_warm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_no |-> !warm_rst_no);

  a_r4_syscfg_por: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_rst_no |-> !syscfg_rst_no);

  a_r5_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_req_i) |=> !syscfg_rst_no);

  a_r6_dbg_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_no |-> !dbg_rst_no);

  a_r7_core_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_warm_rst_no & ~core_cold_rst_no) == '0);

  a_r8_hold_on_warm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_rst_no |-> (!fper_rst_no && !per_rst_no && !sper_rst_no));

  a_r8_sw_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fper_rst_no) |-> $past(reg_we_i && (reg_addr_i == A_HOLD)));

  a_r10_mem_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_no |-> !memport_rst_no);

  a_r11_wdog_warm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wdog_to_i) |=> !warm_rst_no);
endmodule

bind rst_domain_ctrl rdc_checker #(.N_CORE(N_CORE), .N_WDOG(N_WDOG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .warm_req_i(warm_req_i), .wdog_to_i(wdog_to_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .por_rst_no(por_rst_no),
  .cold_rst_no(cold_rst_no), .warm_rst_no(warm_rst_no), .syscfg_rst_no(syscfg_rst_no),
  .dbg_rst_no(dbg_rst_no), .core_cold_rst_no(core_cold_rst_no),
  .core_warm_rst_no(core_warm_rst_no), .fper_rst_no(fper_rst_no),
  .per_rst_no(per_rst_no), .sper_rst_no(sper_rst_no), .memport_rst_no(memport_rst_no)
);

// File: tb/rst_domain_ctrl_tb_top.sv
module rst_domain_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CORE = 4;
  localparam int N_WDOG = 4;
  localparam int REG_W  = 2 * N_CORE + 2;

  localparam int S_POR = 0, S_COLD = 1, S_WARM = 2, S_CFG = 3, S_DBG = 4, S_CC = 5,
                 S_CW = 6, S_FPER = 7, S_PER = 8, S_SPER = 9, S_BRG = 10, S_MEM = 11,
                 S_TAP = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic proc_pgood = 1'b0, fab_pgood = 1'b0, cold_req = 1'b0, warm_req = 1'b0, dbg_req = 1'b0;
  logic [N_WDOG-1:0] wdog = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic por_n, cold_n, warm_n, cfg_n, dbg_n, fper_n, per_n, sper_n, brg_n, mem_n, tap_n;
  logic [N_CORE-1:0] cc_n, cw_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rst_domain_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .proc_pgood_i(proc_pgood), .fab_pgood_i(fab_pgood),
    .cold_req_i(cold_req), .warm_req_i(warm_req), .wdog_to_i(wdog), .dbg_req_i(dbg_req),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .por_rst_no(por_n), .cold_rst_no(cold_n), .warm_rst_no(warm_n), .syscfg_rst_no(cfg_n),
    .dbg_rst_no(dbg_n), .core_cold_rst_no(cc_n), .core_warm_rst_no(cw_n),
    .fper_rst_no(fper_n), .per_rst_no(per_n), .sper_rst_no(sper_n),
    .bridge_rst_no(brg_n), .memport_rst_no(mem_n), .tap_rst_no(tap_n)
  );

  typedef struct {
    int         sel;
    logic [3:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [3:0] obs(int sel);
    case (sel)
      S_POR:  return {3'b0, por_n};
      S_COLD: return {3'b0, cold_n};
      S_WARM: return {3'b0, warm_n};
      S_CFG:  return {3'b0, cfg_n};
      S_DBG:  return {3'b0, dbg_n};
      S_CC:   return cc_n;
      S_CW:   return cw_n;
      S_FPER: return {3'b0, fper_n};
      S_PER:  return {3'b0, per_n};
      S_SPER: return {3'b0, sper_n};
      S_BRG:  return {3'b0, brg_n};
      S_MEM:  return {3'b0, mem_n};
      default: return {3'b0, tap_n};
    endcase
  endfunction

  task automatic exp_sig(int sel, logic [3:0] v, string req);
    item_t it;
    it.sel = sel;
    it.exp = v;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations half a period after the edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (obs(it.sel) !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, obs(it.sel), it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [REG_W-1:0] d);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(); step();
    exp_sig(S_POR, 0, "R1"); exp_sig(S_FPER, 0, "R1"); exp_sig(S_TAP, 0, "R1");
    exp_sig(S_CC, 4'h0, "R1"); exp_sig(S_BRG, 0, "R1");
    rst_ni = 1'b1;
    step();
    exp_sig(S_POR, 0, "R2"); exp_sig(S_CFG, 0, "R4"); exp_sig(S_TAP, 0, "R2");
    proc_pgood = 1'b1;
    step();
    exp_sig(S_POR, 0, "R2 one supply");
    fab_pgood = 1'b1;
    step();
    exp_sig(S_POR, 1, "R2"); exp_sig(S_TAP, 1, "R2"); exp_sig(S_COLD, 1, "R3");
    exp_sig(S_WARM, 1, "R3"); exp_sig(S_CFG, 1, "R4"); exp_sig(S_DBG, 1, "R6");
    exp_sig(S_CC, 4'hF, "R7"); exp_sig(S_CW, 4'hF, "R7");
    exp_sig(S_FPER, 0, "R8 held"); exp_sig(S_BRG, 0, "R9 held"); exp_sig(S_MEM, 1, "R10");
    wr(2'd0, '0);
    exp_sig(S_FPER, 1, "R8"); exp_sig(S_PER, 1, "R8"); exp_sig(S_SPER, 1, "R8");
    exp_sig(S_BRG, 1, "R9");

    // R3/R5 warm request held
    warm_req = 1'b1;
    step();
    exp_sig(S_WARM, 0, "R3"); exp_sig(S_COLD, 1, "R3"); exp_sig(S_DBG, 1, "R6 warm");
    exp_sig(S_TAP, 1, "R2"); exp_sig(S_CC, 4'hF, "R3"); exp_sig(S_CW, 4'h0, "R3");
    exp_sig(S_CFG, 0, "R5"); exp_sig(S_FPER, 0, "R8"); exp_sig(S_BRG, 0, "R9");
    exp_sig(S_MEM, 0, "R10");
    for (int i = 0; i < 3; i++) begin
      step();
      exp_sig(S_CFG, 0, "R5 pulse");
    end
    step();
    exp_sig(S_CFG, 1, "R5 end"); exp_sig(S_WARM, 0, "R5 level");
    warm_req = 1'b0;
    step();
    exp_sig(S_WARM, 1, "R3"); exp_sig(S_MEM, 1, "R10 auto"); exp_sig(S_FPER, 0, "R8 stays");

    // R8/R11 collision: watchdog with software clear
    wdog = 4'b0100;
    wr(2'd0, '0);
    wdog = '0;
    exp_sig(S_FPER, 0, "R8 event wins"); exp_sig(S_WARM, 0, "R11");
    step();
    exp_sig(S_WARM, 1, "R11 one cycle"); exp_sig(S_FPER, 0, "R8");
    wr(2'd0, '0);
    exp_sig(S_FPER, 1, "R8"); exp_sig(S_BRG, 1, "R9");

    // R9/R10 masks against watchdog
    wr(2'd2, 10'h003);
    wdog = 4'b0001;
    step();
    wdog = '0;
    exp_sig(S_WARM, 0, "R11"); exp_sig(S_FPER, 0, "R11"); exp_sig(S_BRG, 1, "R9 mask");
    exp_sig(S_MEM, 1, "R10 mask");
    wr(2'd0, '0);
    exp_sig(S_FPER, 1, "R8");

    // R12 software warm trigger under mask
    wr(2'd1, 10'h200);
    exp_sig(S_WARM, 1, "R12 latency");
    step();
    exp_sig(S_WARM, 0, "R12"); exp_sig(S_CW, 4'h0, "R12"); exp_sig(S_FPER, 0, "R12");
    exp_sig(S_BRG, 1, "R12 mask"); exp_sig(S_MEM, 1, "R12 mask"); exp_sig(S_CFG, 1, "R5 no edge");
    step();
    exp_sig(S_WARM, 1, "R12 self-clear");
    wr(2'd2, '0);
    wr(2'd0, '0);
    exp_sig(S_FPER, 1, "R8");

    // R9 software bridge request
    wr(2'd0, 10'h008);
    exp_sig(S_BRG, 0, "R9 sw set"); exp_sig(S_FPER, 1, "R9");
    wr(2'd0, '0);
    exp_sig(S_BRG, 1, "R9 sw clear");

    // R3/R5 cold request held
    cold_req = 1'b1;
    step();
    exp_sig(S_COLD, 0, "R3"); exp_sig(S_WARM, 0, "R3"); exp_sig(S_DBG, 0, "R6");
    exp_sig(S_CC, 4'h0, "R3"); exp_sig(S_CW, 4'h0, "R3"); exp_sig(S_POR, 1, "R3");
    exp_sig(S_TAP, 1, "R2 cold"); exp_sig(S_BRG, 0, "R9"); exp_sig(S_CFG, 0, "R5");
    for (int i = 0; i < 3; i++) step();
    step();
    exp_sig(S_CFG, 1, "R5 cold end"); exp_sig(S_COLD, 0, "R5 level");
    cold_req = 1'b0;
    step();
    exp_sig(S_COLD, 1, "R3"); exp_sig(S_DBG, 1, "R6");
    wr(2'd0, '0);

    // R6 debugger and software debug
    dbg_req = 1'b1;
    step();
    exp_sig(S_DBG, 0, "R6 dbg_req"); exp_sig(S_COLD, 1, "R6");
    dbg_req = 1'b0;
    wr(2'd1, 10'h100);
    exp_sig(S_DBG, 1, "R7 latency");
    step();
    exp_sig(S_DBG, 0, "R6 sw");
    wr(2'd1, '0);
    exp_sig(S_DBG, 0, "R6");
    step();
    exp_sig(S_DBG, 1, "R6 sw release");

    // R7 per-core software requests
    wr(2'd1, 10'h024);
    step();
    exp_sig(S_CC, 4'b1011, "R7"); exp_sig(S_CW, 4'b1001, "R7"); exp_sig(S_COLD, 1, "R7");
    wr(2'd1, '0);
    step();
    exp_sig(S_CC, 4'hF, "R7"); exp_sig(S_CW, 4'hF, "R7");

    // R2/R4 supply drop
    fab_pgood = 1'b0;
    step();
    exp_sig(S_POR, 0, "R2"); exp_sig(S_TAP, 0, "R2"); exp_sig(S_CFG, 0, "R4");
    exp_sig(S_COLD, 0, "R3"); exp_sig(S_FPER, 0, "R8"); exp_sig(S_MEM, 0, "R10");
    fab_pgood = 1'b1;
    step();
    exp_sig(S_POR, 1, "R2"); exp_sig(S_CFG, 1, "R4"); exp_sig(S_FPER, 0, "R8 held");

    step();
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule